// File: doc/BRIEF.md
# USB Speed Negotiation and High-Speed Fallback Controller

This block sits in a USB peripheral and decides which signalling speed the device uses. It starts at full speed when the bus supply appears. When it sees a bus reset, it drives its own chirp and then listens for the host's alternating chirp pattern. A host that answers with enough K-to-J pairs moves the device into high-speed operation. If no answer arrives, the device stays at full speed.

In high-speed operation the block watches for bus activity. After a long quiet period it drops back to full-speed signalling and times how long the line then holds SE0. An SE0 that lasts long enough inside the check window counts as a reset and restarts the chirp handshake. If no qualifying SE0 appears in that window, the device enters suspend. From suspend, a resume K returns it to high speed, and a reset SE0 starts a new handshake.

All durations are counted in ticks of a single timebase strobe. They are parameters, so a simulation can use short values. The line state is a decoded 2-bit sample, and every output is a plain level decoded from the controller state. There is no data stream and no handshake at the edges of the block.

Top module: `hs_detect_ctrl`

## Requirements
- R1: With `vbus_ok` low, all five outputs are 0. The first clock edge with `vbus_ok` high moves the device to full speed: `pullup_en`=1, and `hs_mode`, `term_en`, `chirp_tx` and `suspend` are all 0.
- R2: `line_state` is encoded as 00=SE0, 01=J, 10=K, 11=SE1. At full speed, an SE0 held for fewer than T_SE0_MIN consecutive ticks leaves the outputs unchanged. The edge that completes T_SE0_MIN consecutive SE0 ticks raises `chirp_tx`.
- R3: `chirp_tx` stays high for exactly T_CHIRP ticks, with `pullup_en`=1 and `term_en`=0 for the whole chirp. It then falls, and the device waits for the host without entering high speed.
- R4: While waiting for the host, a K-to-J transition is a sample of K followed by a sample of J. The edge that completes the N_PAIRS-th such transition, before the wait timeout, sets `hs_mode`=1 and `term_en`=1 and clears `pullup_en`.
- R5: If fewer than N_PAIRS transitions arrive within T_HOST_WAIT ticks, the device stays at full speed. It ignores later host chirps. It starts no new chirp until the line has left SE0 and a fresh SE0 of T_SE0_MIN ticks occurs.
- R6: In high speed, T_IDLE consecutive ticks without `bus_active` return the device to full-speed signalling: `hs_mode`=0, `term_en`=0, `pullup_en`=1. Any cycle with `bus_active` restarts this count.
- R7: After that fallback, an SE0 of T_SE0_MIN consecutive ticks completed inside the T_SE0_MAX-tick window raises `chirp_tx` again.
- R8: If the T_SE0_MAX-tick window ends without a qualifying SE0, `suspend` rises. Shorter SE0 bursts inside the window do not prevent this.
- R9: In suspend, a K sample returns the device to high speed. An SE0 of T_SE0_MIN ticks raises `chirp_tx`. A J sample keeps it suspended.
- R10: A cycle with `vbus_ok` low forces all outputs to 0 at the next edge, from any state.
- R12: Timers advance only on cycles with `tick` high. With `tick` low, no timeout or SE0 qualification completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vbus_ok | input | 1 | Bus supply present |
| tick | input | 1 | Timebase strobe; one timer unit per high cycle |
| line_state | input | 2 | Decoded line: 00 SE0, 01 J, 10 K, 11 SE1 |
| bus_active | input | 1 | High-speed bus activity seen this cycle |
| hs_mode | output | 1 | High-speed signalling selected |
| pullup_en | output | 1 | Connect the full-speed pull-up |
| term_en | output | 1 | Enable high-speed terminations |
| chirp_tx | output | 1 | Request the device chirp K |
| suspend | output | 1 | Device suspended |

## Verification
The bench probes each threshold at its exact edge: the SE0 tick that qualifies a reset, the final chirp cycle, the last idle tick, and the window end. A design that is off by one there would chirp, fall back or suspend one cycle early or late. Host pairs are sent once just before the wait timeout and once just after it. This catches a design that measures the timeout wrongly, or one that still accepts late pairs and jumps to high speed. Other stimulus targets specific faults. An activity pulse during the idle count exposes a design that fails to restart the count. Cycles with `tick` held low expose a timer that counts plain clocks. A run of SE0 continuing after an aborted handshake exposes a design that loops straight back into chirping.

// File: rtl/hsd_pkg.sv
package hsd_pkg;

  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_e;

  typedef enum logic [2:0] {
    ST_DETACHED,
    ST_FS,
    ST_CHIRP,
    ST_WAIT,
    ST_HS,
    ST_REVERT,
    ST_SUSP
  } st_e;

  typedef struct packed {
    logic hs;
    logic pu;
    logic term;
    logic chirp;
    logic susp;
  } pins_t;

  function automatic pins_t pins_of(st_e s);
    pins_t p;
    p = '0;
    case (s)
      ST_FS, ST_WAIT, ST_REVERT: p.pu = 1'b1;
      ST_CHIRP: begin p.pu = 1'b1; p.chirp = 1'b1; end
      ST_HS:    begin p.hs = 1'b1; p.term = 1'b1; end
      ST_SUSP:  begin p.pu = 1'b1; p.susp = 1'b1; end
      default:  p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/hsd_tick_timer.sv
module hsd_tick_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  // saturating up-counter; clear wins over increment
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (clr)                 cnt <= '0;
    else if (inc && cnt != '1)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hsd_pair_counter.sv
module hsd_pair_counter #(
  parameter int N_PAIRS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [1:0] line,
  output logic       hit
);
  import hsd_pkg::*;
  localparam int PW = (N_PAIRS < 2) ? 1 : $clog2(N_PAIRS + 1);

  logic [1:0]    prev;
  logic [PW-1:0] pairs;
  logic          kj;

  assign kj  = (prev == LS_K) && (line == LS_J);
  assign hit = kj && !clr && (pairs == PW'(N_PAIRS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev  <= LS_J;
      pairs <= '0;
    end else begin
      prev <= line;
      if (clr)     pairs <= '0;
      else if (kj) pairs <= pairs + 1'b1;
    end
  end
endmodule

// File: rtl/hs_detect_ctrl.sv
module hs_detect_ctrl #(
  parameter int T_SE0_MIN   = 100,
  parameter int T_SE0_MAX   = 875,
  parameter int T_IDLE      = 3000,
  parameter int T_CHIRP     = 1000,
  parameter int T_HOST_WAIT = 6000,
  parameter int N_PAIRS     = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vbus_ok,
  input  logic       tick,
  input  logic [1:0] line_state,
  input  logic       bus_active,
  output logic       hs_mode,
  output logic       pullup_en,
  output logic       term_en,
  output logic       chirp_tx,
  output logic       suspend
);
  import hsd_pkg::*;

  localparam int M1 = (T_SE0_MAX > T_IDLE) ? T_SE0_MAX : T_IDLE;
  localparam int M2 = (M1 > T_CHIRP) ? M1 : T_CHIRP;
  localparam int M3 = (M2 > T_HOST_WAIT) ? M2 : T_HOST_WAIT;
  localparam int M4 = (M3 > T_SE0_MIN) ? M3 : T_SE0_MIN;
  localparam int CW = $clog2(M4 + 1);

  st_e         st, nx;
  logic        se0_blk;
  logic        is_se0;
  logic        main_clr, main_inc, se0_clr, se0_inc;
  logic        se0_hit, pair_hit;
  logic [CW-1:0] main_cnt, se0_cnt;
  pins_t       pins;

  assign is_se0 = (line_state == LS_SE0);

  // state timer: chirp length, host wait, idle, fallback window
  assign main_clr = (nx != st) || ((st == ST_HS) && bus_active);
  assign main_inc = tick && !((st == ST_HS) && bus_active);
  // consecutive-SE0 timer
  assign se0_clr  = (nx != st) || !is_se0;
  assign se0_inc  = tick && is_se0;
  assign se0_hit  = se0_inc && (se0_cnt == CW'(T_SE0_MIN - 1));

  hsd_tick_timer #(.W(CW)) u_main_tmr (
    .clk(clk), .rst_n(rst_n), .clr(main_clr), .inc(main_inc), .cnt(main_cnt)
  );

  hsd_tick_timer #(.W(CW)) u_se0_tmr (
    .clk(clk), .rst_n(rst_n), .clr(se0_clr), .inc(se0_inc), .cnt(se0_cnt)
  );

  hsd_pair_counter #(.N_PAIRS(N_PAIRS)) u_pairs (
    .clk(clk), .rst_n(rst_n), .clr(st != ST_WAIT), .line(line_state), .hit(pair_hit)
  );

  always_comb begin
    nx = st;
    if (!vbus_ok) begin
      nx = ST_DETACHED;
    end else begin
      case (st)
        ST_DETACHED: nx = ST_FS;
        ST_FS:       if (se0_hit && !se0_blk) nx = ST_CHIRP;
        ST_CHIRP:    if (main_inc && main_cnt == CW'(T_CHIRP - 1)) nx = ST_WAIT;
        ST_WAIT: begin
          if (pair_hit) nx = ST_HS;
          else if (tick && main_cnt == CW'(T_HOST_WAIT - 1)) nx = ST_FS;
        end
        ST_HS:       if (main_inc && main_cnt == CW'(T_IDLE - 1)) nx = ST_REVERT;
        ST_REVERT: begin
          if (se0_hit) nx = ST_CHIRP;
          else if (tick && main_cnt == CW'(T_SE0_MAX - 1)) nx = ST_SUSP;
        end
        ST_SUSP: begin
          if (se0_hit) nx = ST_CHIRP;
          else if (line_state == LS_K) nx = ST_HS;
        end
        default:     nx = ST_DETACHED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_DETACHED;
      se0_blk <= 1'b0;
    end else begin
      st <= nx;
      // an aborted handshake leaves the reset SE0 on the line: ignore it
      if (st == ST_WAIT && nx == ST_FS) se0_blk <= 1'b1;
      else if (!is_se0 || st == ST_DETACHED) se0_blk <= 1'b0;
    end
  end

  assign pins      = pins_of(st);
  assign hs_mode   = pins.hs;
  assign pullup_en = pins.pu;
  assign term_en   = pins.term;
  assign chirp_tx  = pins.chirp;
  assign suspend   = pins.susp;

endmodule

// File: rtl/hsd_checker.sv
module hsd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       vbus_ok,
  input logic       tick,
  input logic [1:0] line_state,
  input logic       hs_mode,
  input logic       pullup_en,
  input logic       term_en,
  input logic       chirp_tx,
  input logic       suspend
);
  // R10
  vbus_drop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vbus_ok |=> (!hs_mode && !pullup_en && !term_en && !chirp_tx && !suspend));

  // R1
  attach_fs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vbus_ok) |=> (pullup_en && !hs_mode && !chirp_tx));

  // R3
  chirp_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chirp_tx) |-> !hs_mode);

  // R4
  hs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_mode) |-> $past(pullup_en));

  // R6
  revert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hs_mode) && $past(vbus_ok)) |-> (pullup_en && !suspend && !chirp_tx));

  // R8
  susp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspend) |-> $past(pullup_en && !hs_mode));

  // R12
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_mode) |-> ($past(tick) || !$past(vbus_ok)));

  // R2
  chirp_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chirp_tx) |-> ($past(tick) && $past(line_state) == 2'b00));
endmodule

bind hs_detect_ctrl hsd_checker u_hsd_chk (
  .clk(clk), .rst_n(rst_n), .vbus_ok(vbus_ok), .tick(tick),
  .line_state(line_state), .hs_mode(hs_mode), .pullup_en(pullup_en),
  .term_en(term_en), .chirp_tx(chirp_tx), .suspend(suspend)
);

// File: tb/tb_hs_detect_ctrl.sv
module tb_hs_detect_ctrl;
  localparam int P_SE0_MIN = 4;
  localparam int P_SE0_MAX = 12;
  localparam int P_IDLE    = 8;
  localparam int P_CHIRP   = 5;
  localparam int P_WAIT    = 20;
  localparam int P_PAIRS   = 3;

  localparam logic [1:0] S0 = 2'b00, LJ = 2'b01, LK = 2'b10, S1 = 2'b11;
  // {hs_mode, pullup_en, term_en, chirp_tx, suspend}
  localparam logic [4:0] V_OFF = 5'b00000, V_FS = 5'b01000, V_CH = 5'b01010,
                         V_HS  = 5'b10100, V_SU = 5'b01001;

  logic clk = 1'b0, rst_n = 1'b0, vbus_ok = 1'b0, tick = 1'b0, bus_active = 1'b0;
  logic [1:0] line_state = 2'b01;
  logic hs_mode, pullup_en, term_en, chirp_tx, suspend;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [4:0] exp_q[$];
  string      tag_q[$];
  wire  [4:0] obs = {hs_mode, pullup_en, term_en, chirp_tx, suspend};

  always #5 clk = ~clk;

  hs_detect_ctrl #(
    .T_SE0_MIN(P_SE0_MIN), .T_SE0_MAX(P_SE0_MAX), .T_IDLE(P_IDLE),
    .T_CHIRP(P_CHIRP), .T_HOST_WAIT(P_WAIT), .N_PAIRS(P_PAIRS)
  ) dut (
    .clk(clk), .rst_n(rst_n), .vbus_ok(vbus_ok), .tick(tick),
    .line_state(line_state), .bus_active(bus_active), .hs_mode(hs_mode),
    .pullup_en(pullup_en), .term_en(term_en), .chirp_tx(chirp_tx), .suspend(suspend)
  );

  // monitor: pops one expected item per cycle, compares mid-cycle
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [4:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (obs !== e) begin
        n_bad++;
        $display("FAIL %s: actual %b expected %b", t, obs, e);
      end
    end
  end

  // driver: set inputs, clock once, queue the expected output vector
  task automatic step(input logic [1:0] ln, input logic act, input logic tk,
                      input logic vb, input logic [4:0] e, input string t);
    @(negedge clk);
    line_state = ln; bus_active = act; tick = tk; vbus_ok = vb;
    @(posedge clk);
    #1;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic rep(input int n, input logic [1:0] ln, input logic act,
                     input logic tk, input logic [4:0] e, input string t);
    for (int i = 0; i < n; i++) step(ln, act, tk, 1'b1, e, t);
  endtask

  // from full speed: reset, chirp, host pairs, high speed
  task automatic go_hs(input string t);
    rep(P_SE0_MIN - 1, S0, 0, 1, V_FS, t);
    step(S0, 0, 1, 1, V_CH, t);
    rep(P_CHIRP - 1, S0, 0, 1, V_CH, t);
    step(S0, 0, 1, 1, V_FS, t);
    step(LK, 0, 1, 1, V_FS, t); step(LJ, 0, 1, 1, V_FS, t);
    step(LK, 0, 1, 1, V_FS, t); step(LJ, 0, 1, 1, V_FS, t);
    step(LK, 0, 1, 1, V_FS, t); step(LJ, 0, 1, 1, V_HS, t);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_chk++;
    if (obs !== V_OFF) begin
      n_bad++;
      $display("FAIL R1 reset state: actual %b expected %b", obs, V_OFF);
    end
    @(negedge clk); rst_n = 1'b1;

    // R1 attach
    step(LJ, 0, 1, 0, V_OFF, "R1 detached");
    step(LJ, 0, 1, 1, V_FS,  "R1 attach");

    // R2 reset qualification
    rep(3, S0, 0, 1, V_FS, "R2 short SE0");
    step(LJ, 0, 1, 1, V_FS, "R2 SE0 broken");
    step(S1, 0, 1, 1, V_FS, "R2 SE1 not SE0");
    rep(3, S0, 0, 1, V_FS, "R2 below min");
    step(S0, 0, 1, 1, V_CH, "R2 reset at min");

    // R3 chirp length
    rep(P_CHIRP - 1, S0, 0, 1, V_CH, "R3 chirp held");
    step(S0, 0, 1, 1, V_FS, "R3 chirp end");

    // R4 host pairs
    step(LK, 0, 1, 1, V_FS, "R4 pairs below n"); step(LJ, 0, 1, 1, V_FS, "R4 pairs below n");
    step(LK, 0, 1, 1, V_FS, "R4 pairs below n"); step(LJ, 0, 1, 1, V_FS, "R4 pairs below n");
    step(LK, 0, 1, 1, V_FS, "R4 pairs below n");
    step(LJ, 0, 1, 1, V_HS, "R4 hs entered");

    // R6 idle count with restart, R12 tick gating
    rep(5, LJ, 0, 1, V_HS, "R6 idle partial");
    step(LJ, 1, 1, 1, V_HS, "R6 activity");
    rep(P_IDLE - 1, LJ, 0, 1, V_HS, "R6 count restarted");
    rep(3, LJ, 0, 0, V_HS, "R12 no tick no timeout");
    step(LJ, 0, 1, 1, V_FS, "R6 revert");

    // R7 reset after fallback
    rep(3, S0, 0, 1, V_FS, "R7 se0 counting");
    step(S0, 0, 1, 1, V_CH, "R7 rechirp");

    // R5 handshake timeout, then ignored pairs
    rep(P_CHIRP - 1, S0, 0, 1, V_CH, "R3 chirp held");
    step(S0, 0, 1, 1, V_FS, "R3 chirp end");
    rep(P_WAIT, S0, 0, 1, V_FS, "R5 waiting");
    rep(6, S0, 0, 1, V_FS, "R5 no rechirp on same SE0");
    step(LK, 0, 1, 1, V_FS, "R5 late pairs"); step(LJ, 0, 1, 1, V_FS, "R5 late pairs");
    step(LK, 0, 1, 1, V_FS, "R5 late pairs"); step(LJ, 0, 1, 1, V_FS, "R5 late pairs");
    step(LK, 0, 1, 1, V_FS, "R5 late pairs"); step(LJ, 0, 1, 1, V_FS, "R5 late pairs ignored");
    rep(3, S0, 0, 1, V_FS, "R5 fresh SE0");
    step(S0, 0, 1, 1, V_CH, "R5 new reset chirps");

    // R4 pairs completed one tick before timeout
    rep(P_CHIRP - 1, S0, 0, 1, V_CH, "R3 chirp held");
    step(S0, 0, 1, 1, V_FS, "R3 chirp end");
    rep(13, LJ, 0, 1, V_FS, "R4 quiet wait");
    step(LK, 0, 1, 1, V_FS, "R4 late"); step(LJ, 0, 1, 1, V_FS, "R4 late");
    step(LK, 0, 1, 1, V_FS, "R4 late"); step(LJ, 0, 1, 1, V_FS, "R4 late");
    step(LK, 0, 1, 1, V_FS, "R4 late");
    step(LJ, 0, 1, 1, V_HS, "R4 hs before timeout");

    // R8 suspend after window
    rep(P_IDLE - 1, LJ, 0, 1, V_HS, "R6 idle");
    step(LJ, 0, 1, 1, V_FS, "R6 revert");
    rep(3, LJ, 0, 1, V_FS, "R8 window");
    rep(2, S0, 0, 1, V_FS, "R8 short SE0");
    rep(6, LJ, 0, 1, V_FS, "R8 window");
    step(LJ, 0, 1, 1, V_SU, "R8 suspend");

    // R9 resume and reset from suspend
    rep(3, LJ, 0, 1, V_SU, "R9 stays suspended");
    step(LK, 0, 1, 1, V_HS, "R9 resume to hs");
    rep(P_IDLE - 1, LJ, 0, 1, V_HS, "R6 idle");
    step(LJ, 0, 1, 1, V_FS, "R6 revert");
    rep(P_SE0_MAX - 1, LJ, 0, 1, V_FS, "R8 window");
    step(LJ, 0, 1, 1, V_SU, "R8 suspend");
    rep(3, S0, 0, 1, V_SU, "R9 se0 counting");
    step(S0, 0, 1, 1, V_CH, "R9 reset from suspend");

    // R10 supply loss
    step(S0, 0, 1, 0, V_OFF, "R10 drop during chirp");
    step(LJ, 0, 1, 1, V_FS,  "R10 reattach");
    go_hs("R4 hs again");
    step(LJ, 0, 1, 0, V_OFF, "R10 drop in hs");
    step(LJ, 0, 1, 0, V_OFF, "R10 stays off");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule